// File: doc/BRIEF.md
# Three-Element Dot-Product Sequencer

This block computes the dot product of two signed integer vectors of three elements each. Both vectors live in small register banks inside the block. They are filled through a write port that picks the vector, the element and the value. A single-cycle `start` pulse launches a computation. A controller then walks an element index. On each pass it multiplies the paired elements and adds the product into an accumulator. When the last element has been summed, it raises `done` and holds the sum on `result`.

The controller has four states:

- `ST_IDLE`: the state after reset.
- `ST_INIT`: clears the accumulator and the index.
- `ST_CALC`: does one fetch-multiply-accumulate-increment pass per clock.
- `ST_DONE`: holds the finished sum.

The transitions are:

- IDLE→INIT on `start`.
- INIT→CALC always.
- CALC→CALC while the incremented index is below three.
- CALC→DONE when the incremented index equals three.
- DONE→INIT on `start`.

The element width is a parameter. The accumulator width is also a parameter, and its default leaves two guard bits above a full product.

Top module: `dotseq3`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `result` is 0, and both vectors hold zeros.
- R2: A write with `wr_en`=1 stores `wr_data` into vector A when `wr_sel`=0 or vector B when `wr_sel`=1, at element `wr_idx` (0..2). A write with `wr_idx`=3 changes no element.
- R3: A `start` sampled in ST_IDLE or ST_DONE moves the block to ST_INIT, so `busy` is 1 and `done` is 0 after that edge.
- R4: ST_INIT clears the accumulator and the element index to zero, so no earlier sum leaks into a new result.
- R5: Each ST_CALC cycle reads element i of both vectors, adds their signed product to the accumulator, and increments i.
- R6: The pass with index 2 exits to ST_DONE, so `done`=1 and a valid `result` appear exactly four clock edges after the edge that sampled `start`. `busy` is high for the four cycles before that, and is never high together with `done`.
- R7: Products and sums are signed two's complement. Three products of the most negative element value fit in the accumulator without overflow.
- R8: In ST_DONE, `done` stays 1 and `result` stays stable until the next `start`, even if the vectors are rewritten. The next `start` clears `done`.
- R9: A `start` that arrives while `busy` is 1 has no effect on the sequence or on its result.
- R10: Writes presented while `busy` is 1 are dropped, so they do not change the current result or any later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Vector element write strobe |
| wr_sel | input | 1 | Vector select: 0 = A, 1 = B |
| wr_idx | input | 2 | Element index, 0..2 valid |
| wr_data | input | ELEM_W | Signed element value |
| start | input | 1 | Begin a computation |
| busy | output | 1 | High in ST_INIT and ST_CALC |
| done | output | 1 | High in ST_DONE |
| result | output | ACC_W | Signed dot product |

## Verification
The edge that samples `start` is counted as edge zero. `busy` is due right after that edge, and `done` and `result` are due after the fourth edge. A write takes effect at the edge that samples it. The bench drives every input on falling edges and reads outputs only at falling edges. For each run it checks `done` low after edge three and high after edge four, so a pass that is off by one cycle is reported. Ignored starts and writes are judged by the `result` of the run in progress and of a later run with no further writes.

// File: rtl/dotseq3_pkg.sv
package dotseq3_pkg;
    localparam int VEC_LEN = 3;
    localparam int IDX_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_CALC = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dotseq3_vecbank.sv
module dotseq3_vecbank
    import dotseq3_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [ELEM_W-1:0] wr_data,
    input  logic                     lock,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [ELEM_W-1:0] rd_a,
    output logic signed [ELEM_W-1:0] rd_b
);
    logic signed [ELEM_W-1:0] vec_a [VEC_LEN];
    logic signed [ELEM_W-1:0] vec_b [VEC_LEN];
    logic                     wr_ok;

    assign wr_ok = wr_en && !lock;

    for (genvar g = 0; g < VEC_LEN; g++) begin : g_elem
        logic hit;
        assign hit = wr_ok && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vec_a[g] <= '0;
                vec_b[g] <= '0;
            end else if (hit) begin
                if (wr_sel) vec_b[g] <= wr_data;
                else        vec_a[g] <= wr_data;
            end
        end

        // R10
        wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock |=> ($stable(vec_a[g]) && $stable(vec_b[g])));

        // R2
        wr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx != IDX_W'(g))) |=> ($stable(vec_a[g]) && $stable(vec_b[g])));
    end

    always_comb begin
        rd_a = '0;
        rd_b = '0;
        for (int k = 0; k < VEC_LEN; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_a = vec_a[k];
                rd_b = vec_b[k];
            end
        end
    end
endmodule

// File: rtl/dotseq3_mac.sv
module dotseq3_mac #(
    parameter int ELEM_W = 8,
    parameter int ACC_W  = 2*ELEM_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic signed [ELEM_W-1:0] op_a,
    input  logic signed [ELEM_W-1:0] op_b,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int PROD_W = 2*ELEM_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    assign prod     = op_a * op_b;
    assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= acc + prod_ext;
    end

    // R4
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(acc));
endmodule

// File: rtl/dotseq3_ctrl.sv
module dotseq3_ctrl
    import dotseq3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [IDX_W-1:0] idx,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             busy,
    output logic             done
);
    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nxt;
    logic             at_end;

    assign idx_nxt = idx_q + 1'b1;
    assign at_end  = (idx_nxt == IDX_W'(VEC_LEN));
    assign idx     = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_INIT;
            ST_INIT: state_d = ST_CALC;
            ST_CALC: state_d = at_end ? ST_DONE : ST_CALC;
            ST_DONE: if (start) state_d = ST_INIT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        acc_clr = 1'b0;
        acc_en  = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INIT: begin acc_clr = 1'b1; busy = 1'b1; end
            ST_CALC: begin acc_en  = 1'b1; busy = 1'b1; end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (acc_clr) idx_q <= '0;
        else if (acc_en)  idx_q <= idx_nxt;
    end

    // R4
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> (idx_q == '0 && state_q == ST_CALC));

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |-> (idx_q < IDX_W'(VEC_LEN)));

    // R6
    calc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC && idx_q == IDX_W'(VEC_LEN-1)) |=> (state_q == ST_DONE));

    // R9
    start_busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT || state_q == ST_CALC) |=> (state_q != ST_INIT));
endmodule

// File: rtl/dotseq3.sv
module dotseq3
    import dotseq3_pkg::*;
#(
    parameter int ELEM_W = 8,
    parameter int ACC_W  = 2*ELEM_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [1:0]        wr_idx,
    input  logic [ELEM_W-1:0] wr_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [ACC_W-1:0]  result
);
    logic [IDX_W-1:0]         rd_idx;
    logic                     acc_clr;
    logic                     acc_en;
    logic signed [ELEM_W-1:0] elem_a;
    logic signed [ELEM_W-1:0] elem_b;
    logic signed [ACC_W-1:0]  acc;

    dotseq3_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .idx     (rd_idx),
        .acc_clr (acc_clr),
        .acc_en  (acc_en),
        .busy    (busy),
        .done    (done)
    );

    dotseq3_vecbank #(.ELEM_W(ELEM_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .lock    (busy),
        .rd_idx  (rd_idx),
        .rd_a    (elem_a),
        .rd_b    (elem_b)
    );

    dotseq3_mac #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .op_a  (elem_a),
        .op_b  (elem_b),
        .acc   (acc)
    );

    assign result = acc;

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));
endmodule

// File: tb/test_dotseq3.sv
module test_dotseq3;
    localparam int ELEM_W = 8;
    localparam int ACC_W  = 2*ELEM_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_sel = 1'b0;
    logic [1:0]        wr_idx = '0;
    logic [ELEM_W-1:0] wr_data = '0;
    logic              start = 1'b0;
    logic              busy;
    logic              done;
    logic [ACC_W-1:0]  result;

    int n_chk = 0;
    int n_err = 0;
    int ma [3];
    int mb [3];

    always #10 clk = ~clk;

    dotseq3 #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) i_dotseq3 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data), .start(start),
        .busy(busy), .done(done), .result(result)
    );

    function automatic int model_dot();
        int s = 0;
        for (int k = 0; k < 3; k++) s += ma[k] * mb[k];
        return s;
    endfunction

    function automatic int res_int();
        return int'($signed(result));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 2'(idx); wr_data = ELEM_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (idx < 3) begin
            if (sel) mb[idx] = val; else ma[idx] = val;
        end
    endtask

    task automatic load(input int a0, a1, a2, b0, b1, b2);
        wr(1'b0, 0, a0); wr(1'b0, 1, a1); wr(1'b0, 2, a2);
        wr(1'b1, 0, b0); wr(1'b1, 1, b1); wr(1'b1, 2, b2);
    endtask

    // Pulses start; returns just after the sampling edge E0.
    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // From just after E0: checks launch, timing and the final sum.
    task automatic finish_run(input string req, input int exp);
        chk("R3", {req, " busy after start"}, int'(busy), 1);
        chk("R3", {req, " done after start"}, int'(done), 0);
        repeat (3) @(negedge clk);
        chk("R6", {req, " done early at edge 3"}, int'(done), 0);
        @(negedge clk);
        chk("R6", {req, " done at edge 4"}, int'(done), 1);
        chk("R6", {req, " busy at edge 4"}, int'(busy), 0);
        chk(req, "result", res_int(), exp);
    endtask

    task automatic t_reset();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "result", res_int(), 0);
        pulse_start();
        finish_run("R1", 0);
    endtask

    task automatic t_basic();
        load(1, 2, 3, 4, 5, 6);
        pulse_start();
        finish_run("R5", 32);
        load(7, 0, -3, 2, 9, 4);
        pulse_start();
        finish_run("R4", 2);
    endtask

    task automatic t_signed();
        load(-128, 127, -1, -128, -128, 5);
        pulse_start();
        finish_run("R7", model_dot());
        load(-128, -128, -128, -128, -128, -128);
        pulse_start();
        finish_run("R7", 49152);
        load(-128, -128, -128, 127, 127, 127);
        pulse_start();
        finish_run("R7", -48768);
    endtask

    task automatic t_hold_restart();
        int held;
        load(3, 3, 3, 1, 2, 3);
        pulse_start();
        finish_run("R8", 18);
        held = res_int();
        wr(1'b0, 0, 10);
        repeat (5) @(negedge clk);
        chk("R8", "done held", int'(done), 1);
        chk("R8", "result held", res_int(), held);
        pulse_start();
        chk("R8", "done cleared by restart", int'(done), 0);
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk("R8", "restart result", res_int(), model_dot());
    endtask

    task automatic t_start_busy();
        load(2, -4, 6, 5, 1, -2);
        pulse_start();
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy during ignored start", int'(busy), 1);
        @(negedge clk);
        chk("R9", "done not yet at edge 3", int'(done), 0);
        @(negedge clk);
        chk("R9", "done on time", int'(done), 1);
        chk("R9", "result", res_int(), model_dot());
    endtask

    task automatic t_write_busy();
        int exp;
        load(1, 1, 1, 2, 2, 2);
        exp = model_dot();
        pulse_start();
        wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 2'd1; wr_data = 8'd77;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R10", "result with blocked write", res_int(), exp);
        pulse_start();
        finish_run("R10", exp);
    endtask

    task automatic t_bad_idx();
        int exp;
        load(4, 5, 6, 1, 1, 1);
        exp = model_dot();
        wr(1'b0, 3, 50);
        wr(1'b1, 3, -50);
        pulse_start();
        finish_run("R2", exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin ma[k] = 0; mb[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_signed();
        t_hold_restart();
        t_start_busy();
        t_write_busy();
        t_bad_idx();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule